// File: doc/BRIEF.md
# Integer ALU and Shifter

A purely combinational integer execution unit for a load/store RISC pipeline. Each cycle the decode stage presents two register operands, a constant shift count, a 16-bit instruction constant and an operation code. The unit returns the result word, a write-back enable for the destination register and a flag that requests an arithmetic overflow exception.

The unit pairs each add and subtract with a trapping form and a wrapping form. The trapping form kills its own write-back when signed overflow occurs. For operations that take the instruction constant, the unit widens that constant with sign or with zeros, depending on the operation. Operation codes outside the defined set do nothing: they write nothing and flag nothing.

Top module: `int_alu`

## Requirements
- R1: Trapping add (op 0), trapping subtract (op 2) and trapping add-constant (op 16, sign-extended constant) output the wrapped sum or difference. On signed overflow `ovf_trap`=1 and `wr_en`=0; otherwise `ovf_trap`=0 and `wr_en`=1.
- R2: Wrapping add (op 1), wrapping subtract (op 3) and wrapping add-constant (op 17) give the same result as their trapping forms, with `ovf_trap`=0 and `wr_en`=1 always.
- R3: Register bitwise ops AND (op 4), OR (op 5), XOR (op 6) and NOR (op 7) combine `opnd_a` with `opnd_b`. NOR of a value with itself gives its complement.
- R4: Constant shifts move `opnd_b` by `shamt`: left logical (op 10) and right logical (op 11) fill with zeros, and right arithmetic (op 12) fills with bit 31. For example, 0xabcd1234 shifted right arithmetically by 4 gives 0xfabcd123.
- R5: Variable shifts left logical (op 13), right logical (op 14) and right arithmetic (op 15) move `opnd_b` by `opnd_a[4:0]`. The upper bits of `opnd_a` are ignored.
- R6: Register compares give 1 when `opnd_a` < `opnd_b` and 0 otherwise, signed for op 8 and unsigned for op 9. Comparing 1 with 0xffffffff gives 0 signed and 1 unsigned.
- R7: The constant compares take a sign-extended `imm`: op 18 compares signed and op 19 compares unsigned. Each gives 1 or 0.
- R8: AND (op 20), OR (op 21) and XOR (op 22) with the constant zero-extend `imm` before combining it with `opnd_a`.
- R9: Load-upper (op 23) outputs `imm` in bits 31:16 and zeros in bits 15:0.
- R10: Op codes 24 to 31 give `result`=0, `wr_en`=0 and `ovf_trap`=0.
- R11: `ovf_trap` is 0 for every op other than 0, 2 and 16. Every defined op other than an overflowing trapping op asserts `wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opnd_a | input | 32 | First register operand; also the variable shift count |
| opnd_b | input | 32 | Second register operand; also the value that is shifted |
| shamt | input | 5 | Constant shift count |
| imm | input | 16 | Instruction constant |
| result | output | 32 | Result word |
| wr_en | output | 1 | Destination write-back enable |
| ovf_trap | output | 1 | Arithmetic overflow exception request |

## Verification
The bench tries every op code with every pairing of a set of operand values and a set of constants. The operand values are chosen at the signed and unsigned edges: zero, one, all ones, the most positive and most negative numbers, and mixed patterns. The edge pairs separate signed from unsigned compares and show where overflow begins. A negative constant against a positive one shows whether an operation sign-extends or zero-extends its constant. Shift counts above 31 in `opnd_a` show that only the low five bits are used. The sign-bit patterns separate arithmetic from logical right shifts.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  parameter int OPW  = 5
) (
  input  logic [OPW-1:0]         op_sel,
  input  logic [XLEN-1:0]        opnd_a,
  input  logic [XLEN-1:0]        opnd_b,
  input  logic [$clog2(XLEN)-1:0] shamt,
  input  logic [IMMW-1:0]        imm,
  output logic [XLEN-1:0]        result,
  output logic                   wr_en,
  output logic                   ovf_trap
);
  localparam int SHW = $clog2(XLEN);

  localparam logic [OPW-1:0] OP_ADD_T  = 0,  OP_ADD_W  = 1,  OP_SUB_T  = 2,  OP_SUB_W = 3;
  localparam logic [OPW-1:0] OP_AND    = 4,  OP_OR     = 5,  OP_XOR    = 6,  OP_NOR   = 7;
  localparam logic [OPW-1:0] OP_LTS    = 8,  OP_LTU    = 9;
  localparam logic [OPW-1:0] OP_SHL    = 10, OP_SHR    = 11, OP_SHA    = 12;
  localparam logic [OPW-1:0] OP_SHLV   = 13, OP_SHRV   = 14, OP_SHAV   = 15;
  localparam logic [OPW-1:0] OP_ADDK_T = 16, OP_ADDK_W = 17, OP_LTSK   = 18, OP_LTUK  = 19;
  localparam logic [OPW-1:0] OP_ANDK   = 20, OP_ORK    = 21, OP_XORK   = 22, OP_UPPER = 23;

  logic [XLEN-1:0] k_sx, k_zx, add_rhs, sum, diff;
  logic [SHW-1:0]  sh_cnt;
  logic            use_k, sh_var, add_ovf, sub_ovf;
  logic [XLEN-1:0] shl_v, shr_v, sha_v;

  assign k_sx    = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign k_zx    = {{(XLEN-IMMW){1'b0}}, imm};
  assign use_k   = (op_sel == OP_ADDK_T) || (op_sel == OP_ADDK_W);
  assign add_rhs = use_k ? k_sx : opnd_b;
  assign sum     = opnd_a + add_rhs;
  assign diff    = opnd_a - opnd_b;
  assign add_ovf = (opnd_a[XLEN-1] == add_rhs[XLEN-1]) && (sum[XLEN-1] != opnd_a[XLEN-1]);
  assign sub_ovf = (opnd_a[XLEN-1] != opnd_b[XLEN-1]) && (diff[XLEN-1] != opnd_a[XLEN-1]);

  assign sh_var  = (op_sel == OP_SHLV) || (op_sel == OP_SHRV) || (op_sel == OP_SHAV);
  assign sh_cnt  = sh_var ? opnd_a[SHW-1:0] : shamt;
  assign shl_v   = opnd_b << sh_cnt;
  assign shr_v   = opnd_b >> sh_cnt;
  assign sha_v   = $signed(opnd_b) >>> sh_cnt;

  always_comb begin
    result   = '0;
    wr_en    = 1'b1;
    ovf_trap = 1'b0;
    case (op_sel)
      OP_ADD_T, OP_ADDK_T: begin
        result   = sum;
        ovf_trap = add_ovf;
        wr_en    = !add_ovf;
      end
      OP_ADD_W, OP_ADDK_W: result = sum;
      OP_SUB_T: begin
        result   = diff;
        ovf_trap = sub_ovf;
        wr_en    = !sub_ovf;
      end
      OP_SUB_W: result = diff;
      OP_AND:   result = opnd_a & opnd_b;
      OP_OR:    result = opnd_a | opnd_b;
      OP_XOR:   result = opnd_a ^ opnd_b;
      OP_NOR:   result = ~(opnd_a | opnd_b);
      OP_LTS:   result = {{(XLEN-1){1'b0}}, $signed(opnd_a) < $signed(opnd_b)};
      OP_LTU:   result = {{(XLEN-1){1'b0}}, opnd_a < opnd_b};
      OP_SHL, OP_SHLV: result = shl_v;
      OP_SHR, OP_SHRV: result = shr_v;
      OP_SHA, OP_SHAV: result = sha_v;
      OP_LTSK:  result = {{(XLEN-1){1'b0}}, $signed(opnd_a) < $signed(k_sx)};
      OP_LTUK:  result = {{(XLEN-1){1'b0}}, opnd_a < k_sx};
      OP_ANDK:  result = opnd_a & k_zx;
      OP_ORK:   result = opnd_a | k_zx;
      OP_XORK:  result = opnd_a ^ k_zx;
      OP_UPPER: result = {imm, {(XLEN-IMMW){1'b0}}};
      default:  wr_en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  parameter int OPW  = 5
) (
  input logic [OPW-1:0]  op_sel,
  input logic [IMMW-1:0] imm,
  input logic [XLEN-1:0] result,
  input logic            wr_en,
  input logic            ovf_trap
);
  always_comb begin
    AST_TRAP_KILLS_WRITE: assert (!(ovf_trap && wr_en)); // R1
    AST_WRAP_WRITES: assert (!(op_sel == 1 || op_sel == 3 || op_sel == 17) || (wr_en && !ovf_trap)); // R2
    AST_CMP_IS_BIT: assert (!(op_sel == 8 || op_sel == 9 || op_sel == 18 || op_sel == 19) || result[XLEN-1:1] == '0); // R6
    AST_UPPER_LOW_ZERO: assert (op_sel != 23 || (result[XLEN-IMMW-1:0] == '0 && result[XLEN-1:XLEN-IMMW] == imm)); // R9
    AST_UNDEF_QUIET: assert (op_sel < 24 || (result == '0 && !wr_en && !ovf_trap)); // R10
    AST_OVF_ONLY_TRAP: assert (!ovf_trap || op_sel == 0 || op_sel == 2 || op_sel == 16); // R11
  end
endmodule

bind int_alu int_alu_chk #(.XLEN(XLEN), .IMMW(IMMW), .OPW(OPW)) u_int_alu_chk (
  .op_sel(op_sel), .imm(imm), .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap)
);

// File: tb/test_int_alu.sv
module test_int_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic [4:0]  shamt;
  logic [15:0] imm;
  logic [31:0] result;
  logic        wr_en, ovf_trap;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int_alu i_int_alu (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt), .imm(imm),
    .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap)
  );

  localparam int NV = 14;
  localparam int NK = 6;
  logic [31:0] vals [NV] = '{32'h0, 32'h1, 32'h2, 32'h7fffffff, 32'h80000000, 32'hffffffff,
                             32'habcd1234, 32'hffff0000, 32'h0000ffff, 32'h12345678,
                             32'h80000001, 32'h0000001f, 32'h00000024, 32'h7ffffffe};
  logic [15:0] ks [NK] = '{16'h0, 16'h1, 16'h8000, 16'hffff, 16'h65d9, 16'h7fff};

  function automatic string req_of(input logic [4:0] op);
    case (op)
      0, 2, 16:          return "R1";
      1, 3, 17:          return "R2";
      4, 5, 6, 7:        return "R3";
      8, 9:              return "R6";
      10, 11, 12:        return "R4";
      13, 14, 15:        return "R5";
      18, 19:            return "R7";
      20, 21, 22:        return "R8";
      23:                return "R9";
      default:           return "R10";
    endcase
  endfunction

  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sa, input logic [15:0] k,
                       output logic [31:0] r, output logic w, output logic v);
    longint sa64, sb64, wide;
    longint ks64;
    logic [31:0] kse;
    ks64 = longint'($signed(k));
    kse  = 32'(ks64);
    sa64 = longint'($signed(a));
    sb64 = longint'($signed(b));
    r = 0; w = 1; v = 0;
    case (op)
      0, 1:   begin wide = sa64 + sb64; r = 32'(wide); v = (op == 0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      2, 3:   begin wide = sa64 - sb64; r = 32'(wide); v = (op == 2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      16, 17: begin wide = sa64 + ks64; r = 32'(wide); v = (op == 16) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      4:  r = a & b;
      5:  r = a | b;
      6:  r = a ^ b;
      7:  r = ~(a | b);
      8:  r = (sa64 < sb64) ? 1 : 0;
      9:  r = ({32'h0, a} < {32'h0, b}) ? 1 : 0;
      10: r = 32'(64'(b) * (64'd1 << sa));
      11: r = 32'(64'(b) / (64'd1 << sa));
      12: r = 32'(sb64 >>> sa);
      13: r = 32'(64'(b) * (64'd1 << (a % 32)));
      14: r = 32'(64'(b) / (64'd1 << (a % 32)));
      15: r = 32'(sb64 >>> (a % 32));
      18: r = (sa64 < ks64) ? 1 : 0;
      19: r = ({32'h0, a} < {32'h0, kse}) ? 1 : 0;
      20: r = a & {16'h0, k};
      21: r = a | {16'h0, k};
      22: r = a ^ {16'h0, k};
      23: r = {k, 16'h0};
      default: begin r = 0; w = 0; end
    endcase
    if (v) w = 0;
  endtask

  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sa, input logic [15:0] k);
    @(negedge clk);
    {op_sel, opnd_a, opnd_b, shamt, imm} = {op, a, b, sa, k};
    #1;
  endtask

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h sa=%0d k=%h act={%h,%b,%b} exp={%h,%b,%b}",
               req, op_sel, opnd_a, opnd_b, shamt, imm,
               act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
    end
  endtask

  task automatic run_vec(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sa, input logic [15:0] k);
    logic [31:0] er;
    logic ew, ev;
    apply(op, a, b, sa, k);
    model(op, a, b, sa, k, er, ew, ev);
    check(req_of(op), {result, wr_en, ovf_trap}, {er, ew, ev});
    if (!(op == 0 || op == 2 || op == 16)) check("R11", {33'h0, ovf_trap}, 34'h0);
  endtask

  task automatic directed(input string req, input logic [4:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [4:0] sa, input logic [15:0] k,
                          input logic [31:0] er, input logic ew, input logic ev);
    apply(op, a, b, sa, k);
    check(req, {result, wr_en, ovf_trap}, {er, ew, ev});
  endtask

  initial begin
    {op_sel, opnd_a, opnd_b, shamt, imm} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    directed("R1", 5'd0, 32'h0, 32'h0, 5'd0, 16'h0, 32'h0, 1'b1, 1'b0);
    directed("R1", 5'd0, 32'h7fffffff, 32'h1, 5'd0, 16'h0, 32'h80000000, 1'b0, 1'b1);
    directed("R1", 5'd2, 32'h80000000, 32'h1, 5'd0, 16'h0, 32'h7fffffff, 1'b0, 1'b1);
    directed("R1", 5'd16, 32'h80000000, 32'h0, 5'd0, 16'hffff, 32'h7fffffff, 1'b0, 1'b1);
    directed("R2", 5'd1, 32'h7fffffff, 32'h1, 5'd0, 16'h0, 32'h80000000, 1'b1, 1'b0);
    directed("R3", 5'd7, 32'habcd1234, 32'habcd1234, 5'd0, 16'h0, 32'h5432edcb, 1'b1, 1'b0);
    directed("R3", 5'd6, 32'habcd1234, 32'hffff0000, 5'd0, 16'h0, 32'h54321234, 1'b1, 1'b0);
    directed("R4", 5'd12, 32'h0, 32'habcd1234, 5'd4, 16'h0, 32'hfabcd123, 1'b1, 1'b0);
    directed("R4", 5'd10, 32'h0, 32'habcd1234, 5'd8, 16'h0, 32'hcd123400, 1'b1, 1'b0);
    directed("R5", 5'd14, 32'hffffff10, 32'habcd1234, 5'd3, 16'h0, 32'h0000abcd, 1'b1, 1'b0);
    directed("R6", 5'd8, 32'h1, 32'hffffffff, 5'd0, 16'h0, 32'h0, 1'b1, 1'b0);
    directed("R6", 5'd9, 32'h1, 32'hffffffff, 5'd0, 16'h0, 32'h1, 1'b1, 1'b0);
    directed("R7", 5'd19, 32'hfffffff0, 32'h0, 5'd0, 16'hffff, 32'h1, 1'b1, 1'b0);
    directed("R7", 5'd18, 32'h0, 32'h0, 5'd0, 16'hffff, 32'h0, 1'b1, 1'b0);
    directed("R8", 5'd21, 32'h0, 32'h0, 5'd0, 16'hffff, 32'h0000ffff, 1'b1, 1'b0);
    directed("R9", 5'd23, 32'hffffffff, 32'hffffffff, 5'd0, 16'hac51, 32'hac510000, 1'b1, 1'b0);
    directed("R10", 5'd31, 32'hffffffff, 32'hffffffff, 5'd31, 16'hffff, 32'h0, 1'b0, 1'b0);
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < NV; i++)
        for (int j = 0; j < NV; j++)
          for (int k = 0; k < NK; k++)
            run_vec(5'(op), vals[i], vals[j], 5'((i * 7 + j * 3 + k * 5) % 32), ks[k]);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule